// File: doc/BRIEF.md
# PTP Event Frame Timestamp Unit

This unit watches one direction of an Ethernet byte stream at the MII boundary and keeps its own time-of-day counter (48-bit seconds, 30-bit nanoseconds). The counter adds a programmable nanosecond step on every clock. Whenever a start-of-frame delimiter strobe passes, the unit copies the running time into a candidate register. It then parses the frame as it streams by, looking for a precision-time event message carried directly over Ethernet (with or without one 802.1Q tag), inside IPv4/UDP or inside IPv6/UDP.

When the parser finds an event message (Sync, Delay_Req, Pdelay_Req or Pdelay_Resp), the candidate is committed to the capture register for that message kind. General messages, other traffic and frames that end early leave every capture register untouched. Two frame-scoped flags are driven: a timestamp-point flag for every frame, and a PTP-event flag that rises only once the message kind is known. Software or a servo reads the captures through a plain combinational select port.

The stream side is a tap, not a sink: the unit has no ready output and cannot apply back-pressure, because the line it observes cannot pause. Every byte strobed by `mii_valid_i` is consumed on the edge that samples it. `mii_sfd_i` and `mii_eof_i` are single-cycle strobes, never high in the same cycle as `mii_valid_i`.

Top module: `ptp_ts_unit`

## Requirements
- R1: On reset the time is 0 s, 0 ns. After reset, every clock adds `inc_ns_i` (which must stay below 10^9) to the nanoseconds, and the nanoseconds output never reaches 10^9.
- R2: When nanoseconds plus the step reaches 10^9 or more, the nanoseconds become the sum minus 10^9 and the seconds go up by one in the same clock.
- R3: `ts_point_o` is high from the cycle after a sampled SFD strobe until the cycle after a sampled end-of-frame strobe. This holds for every frame, PTP or not.
- R4: The candidate timestamp equals the time shown on `now_sec_o`/`now_ns_o` during the cycle in which the SFD strobe is sampled.
- R5: Byte positions count from 0 at the first byte after the SFD. EtherType 0x88F7 at bytes 12-13 places the PTP header at byte 14. A single 0x8100 tag at bytes 12-13 moves the EtherType to 16-17 and every later offset up by 4.
- R6: EtherType 0x0800 marks IPv4 PTP when the IP header's first byte is 0x45, its byte 9 is 17 (UDP), and its bytes 22-23 hold destination port 319. The PTP header then starts at IP byte 28.
- R7: EtherType 0x86DD marks IPv6 PTP when IP byte 6 is 17 and IP bytes 42-43 hold port 319. The PTP header then starts at IP byte 48.
- R8: The low nibble of the first PTP byte is the message kind. Values 0 (Sync), 1 (Delay_Req), 2 (Pdelay_Req) and 3 (Pdelay_Resp) are events. Every other value is not an event.
- R9: `ptp_event_o` is low while the kind byte is on the bus. It is high from the cycle after an event kind byte is sampled until the cycle after end of frame.
- R10: On an event, capture register k (k = kind value) is loaded with that frame's candidate at the edge that samples the kind byte. All capture registers reset to zero.
- R11: Non-event kinds, non-PTP frames, wrong ports, wrong protocols and frames ending before the kind byte change no capture register and never raise `ptp_event_o`.
- R12: `rd_sec_o`/`rd_ns_o` show capture register `rd_sel_i` combinationally.
- R13: An SFD strobe arriving while a frame is still open restarts parsing and takes a new candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_ns_i | input | 30 | Nanosecond step per clock |
| mii_valid_i | input | 1 | Data byte strobe |
| mii_data_i | input | 8 | Frame byte |
| mii_sfd_i | input | 1 | Start-frame-delimiter strobe |
| mii_eof_i | input | 1 | End-of-frame strobe |
| now_sec_o | output | 48 | Running seconds |
| now_ns_o | output | 30 | Running nanoseconds |
| ts_point_o | output | 1 | Frame timestamp-point flag |
| ptp_event_o | output | 1 | PTP event frame flag |
| rd_sel_i | input | 2 | Capture register select |
| rd_sec_o | output | 48 | Selected capture, seconds |
| rd_ns_o | output | 30 | Selected capture, nanoseconds |

## Verification
The time outputs reflect k clock steps after k edges out of reset. The candidate is the value visible in the SFD cycle. Both flags change one edge after the strobe or byte that causes them. A capture is readable one edge after its kind byte, through a select path that adds no cycle. The bench drives on falling edges and keeps its own edge count, from which it computes every expected time arithmetically. It then checks each result at the first falling edge after the rising edge where that result is due. Near-exhaustive sweeps cover all 16 kind values under four encapsulations, plus broken headers, truncated frames and restarted frames. After every frame, all four capture registers are read back.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;
  localparam int SEC_W = 48;
  localparam int NS_W  = 30;
  localparam logic [NS_W:0] NS_PER_SEC = 31'd1_000_000_000;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_t;

  typedef enum logic [2:0] {
    ENC_WAIT,
    ENC_L2,
    ENC_V4,
    ENC_V6,
    ENC_DROP
  } enc_e;

  localparam logic [15:0] ETY_PTP  = 16'h88F7;
  localparam logic [15:0] ETY_VLAN = 16'h8100;
  localparam logic [15:0] ETY_IPV4 = 16'h0800;
  localparam logic [15:0] ETY_IPV6 = 16'h86DD;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam logic [7:0]  V4_FIRST  = 8'h45;
  localparam logic [7:0]  PORT_HI   = 8'h01;
  localparam logic [7:0]  PORT_LO   = 8'h3F;
endpackage

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_ts_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS_W-1:0] inc_i,
  output tod_t            now_o
);
  logic [SEC_W-1:0] sec_q;
  logic [NS_W-1:0]  ns_q;
  logic [NS_W:0]    sum;

  assign sum = {1'b0, ns_q} + {1'b0, inc_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (sum >= NS_PER_SEC) begin
      ns_q  <= NS_W'(sum - NS_PER_SEC);
      sec_q <= sec_q + 1'b1;
    end else begin
      ns_q  <= sum[NS_W-1:0];
    end
  end

  assign now_o = '{sec: sec_q, ns: ns_q};

  assert_ns_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ns_q} < NS_PER_SEC));

  assert_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ns_q < $past(ns_q)) == (sec_q == $past(sec_q) + 1'b1)));
endmodule

// File: rtl/ptp_frame_parser.sv
module ptp_frame_parser
  import ptp_ts_pkg::*;
#(
  parameter int POS_W = 11,
  parameter int N_EVT = 4,
  localparam int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sfd_i,
  input  logic             eof_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic             evt_o,
  output logic [SEL_W-1:0] evt_kind_o
);
  localparam logic [POS_W-1:0] L2_HDR   = POS_W'(14);
  localparam logic [POS_W-1:0] TAG_LEN  = POS_W'(4);
  localparam logic [POS_W-1:0] V4_PTP   = POS_W'(28);
  localparam logic [POS_W-1:0] V6_PTP   = POS_W'(48);

  logic             open_q, tag_q;
  logic [POS_W-1:0] pos_q, base_q, rel;
  logic [7:0]       hi_q;
  enc_e             enc_q;
  logic             ptp_here;
  logic [15:0]      ety;

  assign rel = pos_q - base_q;
  assign ety = {hi_q, data_i};

  always_comb begin
    unique case (enc_q)
      ENC_L2:  ptp_here = (rel == '0);
      ENC_V4:  ptp_here = (rel == V4_PTP);
      ENC_V6:  ptp_here = (rel == V6_PTP);
      default: ptp_here = 1'b0;
    endcase
  end

  assign evt_o      = open_q && valid_i && ptp_here && (int'(data_i[3:0]) < N_EVT);
  assign evt_kind_o = data_i[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      tag_q  <= 1'b0;
      pos_q  <= '0;
      base_q <= L2_HDR;
      hi_q   <= '0;
      enc_q  <= ENC_DROP;
    end else if (sfd_i) begin
      open_q <= 1'b1;
      tag_q  <= 1'b0;
      pos_q  <= '0;
      base_q <= L2_HDR;
      enc_q  <= ENC_WAIT;
    end else if (eof_i) begin
      open_q <= 1'b0;
      enc_q  <= ENC_DROP;
    end else if (open_q && valid_i) begin
      if (pos_q != '1) pos_q <= pos_q + 1'b1;
      if (enc_q == ENC_WAIT) begin
        if (pos_q == base_q - POS_W'(2)) begin
          hi_q <= data_i;
        end else if (pos_q == base_q - POS_W'(1)) begin
          if (ety == ETY_VLAN && !tag_q) begin
            tag_q  <= 1'b1;
            base_q <= base_q + TAG_LEN;
          end else if (ety == ETY_PTP)  enc_q <= ENC_L2;
          else if (ety == ETY_IPV4)     enc_q <= ENC_V4;
          else if (ety == ETY_IPV6)     enc_q <= ENC_V6;
          else                          enc_q <= ENC_DROP;
        end
      end else if (ptp_here) begin
        enc_q <= ENC_DROP;
      end else if (enc_q == ENC_V4) begin
        if ((rel == POS_W'(0)  && data_i != V4_FIRST) ||
            (rel == POS_W'(9)  && data_i != PROTO_UDP) ||
            (rel == POS_W'(22) && data_i != PORT_HI) ||
            (rel == POS_W'(23) && data_i != PORT_LO))
          enc_q <= ENC_DROP;
      end else if (enc_q == ENC_V6) begin
        if ((rel == POS_W'(6)  && data_i != PROTO_UDP) ||
            (rel == POS_W'(42) && data_i != PORT_HI) ||
            (rel == POS_W'(43) && data_i != PORT_LO))
          enc_q <= ENC_DROP;
      end
    end
  end

  assert_single_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o && !sfd_i |=> !evt_o);

  assert_no_enc_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && enc_q != ENC_WAIT && enc_q != ENC_DROP) |-> (pos_q >= L2_HDR));
endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture
  import ptp_ts_pkg::*;
#(
  parameter int N_EVT = 4,
  localparam int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [SEL_W-1:0] kind_i,
  input  tod_t             cand_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output tod_t             rd_o
);
  tod_t slot_q [N_EVT];

  for (genvar k = 0; k < N_EVT; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                       slot_q[k] <= '0;
      else if (commit_i && kind_i == SEL_W'(k))         slot_q[k] <= cand_i;
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_i && kind_i == SEL_W'(k)) |=> $stable(slot_q[k]));

    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && kind_i == SEL_W'(k)) |=> (slot_q[k] == $past(cand_i)));
  end

  assign rd_o = slot_q[rd_sel_i];
endmodule

// File: rtl/ptp_ts_unit.sv
module ptp_ts_unit
  import ptp_ts_pkg::*;
#(
  parameter int POS_W = 11,
  parameter int N_EVT = 4,
  localparam int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [29:0]      inc_ns_i,
  input  logic             mii_valid_i,
  input  logic [7:0]       mii_data_i,
  input  logic             mii_sfd_i,
  input  logic             mii_eof_i,
  output logic [47:0]      now_sec_o,
  output logic [29:0]      now_ns_o,
  output logic             ts_point_o,
  output logic             ptp_event_o,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [47:0]      rd_sec_o,
  output logic [29:0]      rd_ns_o
);
  tod_t             now, cand_q, rd;
  logic             evt;
  logic [SEL_W-1:0] kind;
  logic             point_q, evt_q;

  ptp_tod_counter i_tod (
    .clk   (clk),
    .rst_n (rst_n),
    .inc_i (inc_ns_i),
    .now_o (now)
  );

  ptp_frame_parser #(.POS_W(POS_W), .N_EVT(N_EVT)) i_parse (
    .clk        (clk),
    .rst_n      (rst_n),
    .sfd_i      (mii_sfd_i),
    .eof_i      (mii_eof_i),
    .valid_i    (mii_valid_i),
    .data_i     (mii_data_i),
    .evt_o      (evt),
    .evt_kind_o (kind)
  );

  ptp_ts_capture #(.N_EVT(N_EVT)) i_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (evt),
    .kind_i   (kind),
    .cand_i   (cand_q),
    .rd_sel_i (rd_sel_i),
    .rd_o     (rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q  <= '0;
      point_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (mii_sfd_i) cand_q <= now;
      if (mii_sfd_i)      point_q <= 1'b1;
      else if (mii_eof_i) point_q <= 1'b0;
      if (mii_sfd_i)      evt_q <= 1'b0;
      else if (evt)       evt_q <= 1'b1;
      else if (mii_eof_i) evt_q <= 1'b0;
    end
  end

  assign now_sec_o   = now.sec;
  assign now_ns_o    = now.ns;
  assign ts_point_o  = point_q;
  assign ptp_event_o = evt_q;
  assign rd_sec_o    = rd.sec;
  assign rd_ns_o     = rd.ns;

  assert_point_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mii_sfd_i |=> ts_point_o);

  assert_point_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mii_eof_i && !mii_sfd_i |=> !ts_point_o);

  assert_evt_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mii_eof_i && !mii_sfd_i |=> !ptp_event_o);

  assert_evt_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptp_event_o |-> ts_point_o);

  assert_cand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mii_sfd_i |=> (cand_q == $past(now)));
endmodule

// File: tb/test_ptp_ts_unit.sv
module test_ptp_ts_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] inc_ns = 30'd123_456_789;
  logic        valid = 1'b0, sfd = 1'b0, eof = 1'b0;
  logic [7:0]  data = 8'h00;
  logic [1:0]  rd_sel = 2'd0;
  logic [47:0] now_sec, rd_sec;
  logic [29:0] now_ns, rd_ns;
  logic        ts_point, ptp_event;

  int n_cmp = 0;
  int n_bad = 0;
  longint unsigned edges = 0;
  logic [77:0] exp_slot [4];
  logic [7:0]  fb [0:79];
  int flen, pidx;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  ptp_ts_unit i_ptp_ts_unit (
    .clk(clk), .rst_n(rst_n), .inc_ns_i(inc_ns),
    .mii_valid_i(valid), .mii_data_i(data), .mii_sfd_i(sfd), .mii_eof_i(eof),
    .now_sec_o(now_sec), .now_ns_o(now_ns),
    .ts_point_o(ts_point), .ptp_event_o(ptp_event),
    .rd_sel_i(rd_sel), .rd_sec_o(rd_sec), .rd_ns_o(rd_ns)
  );

  function automatic logic [77:0] tod_at(input longint unsigned e);
    longint unsigned t = e * longint'(inc_ns);
    return {48'(t / 64'd1_000_000_000), 30'(t % 64'd1_000_000_000)};
  endfunction

  task automatic chk(input string tag, input logic [77:0] act, input logic [77:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check_slots(input string tag);
    for (int k = 0; k < 4; k++) begin
      rd_sel = 2'(k);
      #1;
      chk(tag, {rd_sec, rd_ns}, exp_slot[k]);
    end
  endtask

  // enc: 0 plain L2, 1 tagged L2, 2 IPv4, 3 IPv6; bad corrupts the match field
  task automatic build(input int enc, input logic [7:0] b0, input bit bad);
    int ip;
    for (int i = 0; i < 80; i++) fb[i] = 8'(i * 7 + 3);
    ip = (enc == 1) ? 18 : 14;
    if (enc == 1) begin fb[12] = 8'h81; fb[13] = 8'h00; end
    case (enc)
      0, 1: begin
        fb[ip-2] = 8'h88; fb[ip-1] = bad ? 8'hF8 : 8'hF7;
        pidx = ip;
      end
      2: begin
        fb[ip-2] = 8'h08; fb[ip-1] = 8'h00;
        fb[ip] = 8'h45; fb[ip+9] = 8'd17;
        fb[ip+22] = 8'h01; fb[ip+23] = bad ? 8'h40 : 8'h3F;
        pidx = ip + 28;
      end
      default: begin
        fb[ip-2] = 8'h86; fb[ip-1] = 8'hDD;
        fb[ip+6] = bad ? 8'd6 : 8'd17;
        fb[ip+42] = 8'h01; fb[ip+43] = 8'h3F;
        pidx = ip + 48;
      end
    endcase
    fb[pidx] = b0;
    flen = pidx + 6;
  endtask

  // sends the built frame; cut > 0 truncates it to cut bytes
  task automatic run_frame(input string tag, input bit is_evt, input int cut);
    logic [77:0] cand;
    int n;
    n = (cut > 0) ? cut : flen;
    @(negedge clk);
    sfd = 1'b1;
    cand = tod_at(edges);
    @(negedge clk);
    sfd = 1'b0;
    chk("R3 point rise", 78'(ts_point), 78'd1);
    for (int i = 0; i < n; i++) begin
      valid = 1'b1;
      data = fb[i];
      if (i == pidx) chk("R9 event low on kind byte", 78'(ptp_event), 78'd0);
      @(negedge clk);
    end
    valid = 1'b0;
    eof = 1'b1;
    chk({tag, " R9/R11 event flag"}, 78'(ptp_event), 78'(is_evt && cut == 0));
    @(negedge clk);
    eof = 1'b0;
    chk("R3 point fall", 78'(ts_point), 78'd0);
    chk("R9 event fall", 78'(ptp_event), 78'd0);
    if (is_evt && cut == 0) exp_slot[fb[pidx][1:0]] = cand;
    check_slots({tag, " R4/R10/R11/R12 capture"});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset time", {now_sec, now_ns}, 78'd0);
    chk("R3 reset point", 78'(ts_point), 78'd0);
    chk("R9 reset event", 78'(ptp_event), 78'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) exp_slot[k] = '0;
    do_reset();
    check_slots("R10 reset slots");

    // R1/R2: step several wraps
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      chk("R1/R2 running time", {now_sec, now_ns}, tod_at(edges));
    end

    // R5..R8, R10, R11: every kind nibble under every encapsulation
    for (int enc = 0; enc < 4; enc++) begin
      for (int nib = 0; nib < 16; nib++) begin
        string tag;
        tag = (enc < 2) ? "R5" : (enc == 2) ? "R6" : "R7";
        build(enc, {4'(nib + 2), 4'(nib)}, 1'b0);
        run_frame({tag, " R8"}, nib < 4, 0);
      end
      // broken match field: never an event (R11)
      build(enc, 8'h00, 1'b1);
      run_frame("R11 bad header", 1'b0, 0);
    end

    // R11: frame ends just before the kind byte
    build(2, 8'h01, 1'b0);
    run_frame("R11 short", 1'b1, pidx);
    build(0, 8'h03, 1'b0);
    run_frame("R11 short L2", 1'b1, pidx);

    // R13: SFD while a frame is open
    build(3, 8'h02, 1'b0);
    @(negedge clk);
    sfd = 1'b1;
    @(negedge clk);
    sfd = 1'b0;
    for (int i = 0; i < 20; i++) begin
      valid = 1'b1; data = fb[i];
      @(negedge clk);
    end
    valid = 1'b0;
    run_frame("R13 restart", 1'b1, 0);

    // R2: largest legal step, carry on nearly every clock
    inc_ns = 30'd999_999_999;
    do_reset();
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      chk("R2 max step", {now_sec, now_ns}, tod_at(edges));
    end

    summary();
    $finish;
  end
endmodule